// File: doc/BRIEF.md
# Fixed-Width Instruction Decode Stage

This block is the decode stage for a small subset of a 32-bit fixed-width RISC instruction set. Each cycle it takes one raw instruction word and a byte-order flag. It registers a decoded record that a later issue stage reads directly. The record holds:

- an internal operation class;
- one write-port and three read-port register selections, each with its own valid bit;
- an extended immediate;
- the record, link, absolute and update flags;
- the memory access size;
- the branch condition fields and the compare target field;
- the rotate shift and mask bounds;
- a selector for the link or count special register.

Instructions that fall outside the subset decode to an illegal class with every port request withdrawn.

Bit numbers below use ordinary little-endian numbering of the 32-bit word (bit 31 is the most significant). The primary opcode is `w[31:26]`. The 10-bit extended opcode is `w[10:1]`. The two 5-bit register fields that follow the opcode are A = `w[25:21]` and B = `w[20:16]`. The third register field is C = `w[15:11]`, and the 16-bit field is `w[15:0]`.

Top module: `pdec_stage`

## Requirements
- R1: When `be_mode` is 1 the input word is decoded as given. When it is 0, its four bytes are reversed (byte 0 swapped with byte 3, byte 1 with byte 2) before any field is read.
- R2: Outputs are registered and show the decode of the word presented one rising edge earlier. While `rst_n` is low every output is 0, which includes op code 0 (illegal).
- R3: `op_o` codes are 0 illegal, 1 add, 2 and, 3 or, 4 load, 5 store, 6 compare, 7 rotate, 8 branch. Recognised encodings:
  - primary opcodes 14, 15 (add immediate, add immediate shifted); 24, 25 (or immediate, or immediate shifted); 28, 29 (and immediate, and immediate shifted); 32–41 and 44–45 (memory); 20, 21, 23 (rotate); 18, 16 (branch);
  - primary opcode 31 with extended opcode 266 (add), 28 (and), 444 (or), 0 (compare), 23 (indexed word load), 151 (indexed word store);
  - primary opcode 19 with extended opcode 16 (branch to link) or 528 (branch to count).
- R4: The immediate is 64 bits wide. The four 16-bit modes are: zero-extended (or immediate, and immediate); zero-extended after a left shift by 16 (the shifted or/and forms); sign-extended (add immediate, memory D-form); sign-extended after a left shift by 16 (add immediate shifted).
- R5: Loads write field A and read the base field B on port 1. Stores read field A on port 3 and the base on port 1. Indexed forms also read field C on port 2. For D-form memory ops and both add-immediate forms, a base field of 0 leaves port 1 invalid.
- R6: Memory size is 4 for opcodes 32, 33, 36, 37 and indexed word ops; 1 for 34, 35, 38, 39; 2 for 40, 41, 44, 45. Stores are 36–39 and 44–45. The update flag equals `w[26]` for D-form memory ops. Size and update are 0 for everything else.
- R7: The record flag equals `w[0]` for register add/and/or and the rotates. It is always 1 for the and-immediate forms and 0 for every other instruction.
- R8: Compare reads field B on port 1 and field C on port 2, and outputs `w[25:23]` as the 3-bit condition field.
- R9: Rotates write field B and read field A on port 3. Mask bounds are `w[10:6]` and `w[5:1]`. Opcodes 20 and 21 output `w[15:11]` as the shift. Opcode 23 instead reads field C on port 2 and outputs shift 0.
- R10: For opcode 18 the immediate is `w[25:2]` times 4, sign-extended from bit 25. For opcode 16 it is `w[15:2]` times 4, sign-extended from bit 15, and the condition fields are A and B. For both, absolute = `w[1]` and link = `w[0]`.
- R11: Opcode 19 branches output condition fields A and B, link = `w[0]`, and a special-register select of 1 (link register, extended opcode 16) or 2 (count register, extended opcode 528). The select is 0 for every other instruction.
- R12: Any other encoding, including opcode 31 with extended opcode 778, yields op 0 with every valid flag, size and select at 0.
- R13: Register add writes A and reads B on port 1 and C on port 2. Register and/or write B and read A on port 3 and C on port 2. Immediate and/or write B and read A on port 3. Both add-immediate forms write A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| be_mode | input | 1 | 1: word is big-endian as given; 0: reverse bytes first |
| insn_i | input | 32 | Raw instruction word |
| op_o | output | 4 | Operation class |
| wr_vld_o | output | 1 | Write port in use |
| wr_idx_o | output | 5 | Write register number |
| rd1_vld_o | output | 1 | Read port 1 in use |
| rd1_idx_o | output | 5 | Read port 1 register |
| rd2_vld_o | output | 1 | Read port 2 in use |
| rd2_idx_o | output | 5 | Read port 2 register |
| rd3_vld_o | output | 1 | Read port 3 in use |
| rd3_idx_o | output | 5 | Read port 3 register |
| imm_o | output | 64 | Extended immediate |
| rc_o | output | 1 | Record flag |
| lk_o | output | 1 | Link flag |
| aa_o | output | 1 | Absolute-address flag |
| upd_o | output | 1 | Base update flag |
| mlen_o | output | 4 | Memory access size in bytes |
| bo_o | output | 5 | Branch condition options |
| bi_o | output | 5 | Branch condition bit index |
| bf_o | output | 3 | Compare target field |
| sh_o | output | 5 | Rotate shift amount |
| mb_o | output | 5 | Mask begin |
| me_o | output | 5 | Mask end |
| spr_o | output | 2 | Special register select |

## Verification
The assertions assume that `rst_n` is low across the first edge, so that the registered record starts from the all-zero illegal state. They also assume that `be_mode` and `insn_i` are settled before each rising edge. They make no assumption about the instruction word itself: any 32-bit pattern must leave a consistent record. The stimulus changes the inputs only on falling edges. It sweeps every register number through each form, uses both byte orders alternately, and includes encodings that must be refused.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

    localparam int INSN_W = 32;
    localparam int RIDX_W = 5;
    localparam int IMM_W  = 64;
    localparam int PO_W   = 6;
    localparam int XO_W   = 10;

    typedef enum logic [3:0] {
        OPC_ILLEGAL = 4'd0,
        OPC_ADD     = 4'd1,
        OPC_AND     = 4'd2,
        OPC_OR      = 4'd3,
        OPC_LOAD    = 4'd4,
        OPC_STORE   = 4'd5,
        OPC_CMP     = 4'd6,
        OPC_ROTATE  = 4'd7,
        OPC_BRANCH  = 4'd8
    } opc_e;

    typedef enum logic [2:0] {
        IMX_NONE = 3'd0,
        IMX_ULO  = 3'd1,
        IMX_UHI  = 3'd2,
        IMX_SLO  = 3'd3,
        IMX_SHI  = 3'd4,
        IMX_LI   = 3'd5,
        IMX_BD   = 3'd6
    } imx_e;

    typedef enum logic [1:0] {
        SPRS_NONE = 2'd0,
        SPRS_LR   = 2'd1,
        SPRS_CTR  = 2'd2
    } sprs_e;

    typedef struct packed {
        logic              vld;
        logic [RIDX_W-1:0] idx;
    } rport_t;

    typedef struct packed {
        opc_e              op;
        rport_t            wr;
        rport_t            rd1;
        rport_t            rd2;
        rport_t            rd3;
        logic [IMM_W-1:0]  imm;
        logic              rc;
        logic              lk;
        logic              aa;
        logic              upd;
        logic [3:0]        mlen;
        logic [4:0]        bo;
        logic [4:0]        bi;
        logic [2:0]        bf;
        logic [4:0]        sh;
        logic [4:0]        mb;
        logic [4:0]        me;
        sprs_e             spr;
    } dec_t;

    localparam logic [PO_W-1:0] PO_BC     = 6'd16;
    localparam logic [PO_W-1:0] PO_B      = 6'd18;
    localparam logic [PO_W-1:0] PO_XL     = 6'd19;
    localparam logic [PO_W-1:0] PO_ROTIMI = 6'd20;
    localparam logic [PO_W-1:0] PO_ROTINM = 6'd21;
    localparam logic [PO_W-1:0] PO_ROTNM  = 6'd23;
    localparam logic [PO_W-1:0] PO_ADDI   = 6'd14;
    localparam logic [PO_W-1:0] PO_ADDIS  = 6'd15;
    localparam logic [PO_W-1:0] PO_ORI    = 6'd24;
    localparam logic [PO_W-1:0] PO_ORIS   = 6'd25;
    localparam logic [PO_W-1:0] PO_ANDI   = 6'd28;
    localparam logic [PO_W-1:0] PO_ANDIS  = 6'd29;
    localparam logic [PO_W-1:0] PO_X      = 6'd31;

    localparam logic [XO_W-1:0] XO_CMP   = 10'd0;
    localparam logic [XO_W-1:0] XO_LDX   = 10'd23;
    localparam logic [XO_W-1:0] XO_AND   = 10'd28;
    localparam logic [XO_W-1:0] XO_STX   = 10'd151;
    localparam logic [XO_W-1:0] XO_ADD   = 10'd266;
    localparam logic [XO_W-1:0] XO_OR    = 10'd444;
    localparam logic [XO_W-1:0] XO_TOLR  = 10'd16;
    localparam logic [XO_W-1:0] XO_TOCTR = 10'd528;

endpackage

// File: rtl/pdec_swap.sv
module pdec_swap #(
    parameter int W = 32
) (
    input  logic         be,
    input  logic [W-1:0] raw,
    output logic [W-1:0] word
);
    localparam int NBYTES = W / 8;

    logic [W-1:0] rev;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign rev[8*b +: 8] = raw[8*(NBYTES-1-b) +: 8];
    end

    assign word = be ? raw : rev;
endmodule

// File: rtl/pdec_imm.sv
module pdec_imm
    import pdec_pkg::*;
#(
    parameter int OUT_W = 64
) (
    input  logic [25:0]      fld,
    input  imx_e             mode,
    output logic [OUT_W-1:0] imm
);
    localparam int LI_W = 26;
    localparam int BD_W = 16;

    logic [15:0]     half;
    logic [LI_W-1:0] li_ext;
    logic [BD_W-1:0] bd_ext;

    assign half   = fld[15:0];
    assign li_ext = {fld[25:2], 2'b00};
    assign bd_ext = {fld[15:2], 2'b00};

    always_comb begin
        unique case (mode)
            IMX_ULO: imm = {{(OUT_W-16){1'b0}}, half};
            IMX_UHI: imm = {{(OUT_W-32){1'b0}}, half, 16'h0000};
            IMX_SLO: imm = {{(OUT_W-16){half[15]}}, half};
            IMX_SHI: imm = {{(OUT_W-32){half[15]}}, half, 16'h0000};
            IMX_LI:  imm = {{(OUT_W-LI_W){li_ext[LI_W-1]}}, li_ext};
            IMX_BD:  imm = {{(OUT_W-BD_W){bd_ext[BD_W-1]}}, bd_ext};
            default: imm = '0;
        endcase
    end
endmodule

// File: rtl/pdec_stage.sv
module pdec_stage
    import pdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              be_mode,
    input  logic [INSN_W-1:0] insn_i,
    output logic [3:0]        op_o,
    output logic              wr_vld_o,
    output logic [RIDX_W-1:0] wr_idx_o,
    output logic              rd1_vld_o,
    output logic [RIDX_W-1:0] rd1_idx_o,
    output logic              rd2_vld_o,
    output logic [RIDX_W-1:0] rd2_idx_o,
    output logic              rd3_vld_o,
    output logic [RIDX_W-1:0] rd3_idx_o,
    output logic [IMM_W-1:0]  imm_o,
    output logic              rc_o,
    output logic              lk_o,
    output logic              aa_o,
    output logic              upd_o,
    output logic [3:0]        mlen_o,
    output logic [4:0]        bo_o,
    output logic [4:0]        bi_o,
    output logic [2:0]        bf_o,
    output logic [4:0]        sh_o,
    output logic [4:0]        mb_o,
    output logic [4:0]        me_o,
    output logic [1:0]        spr_o
);
    logic [INSN_W-1:0] word_w;
    logic [PO_W-1:0]   po_w;
    logic [XO_W-1:0]   xo_w;
    logic [RIDX_W-1:0] fa_w, fb_w, fc_w;
    logic [IMM_W-1:0]  imm_w;
    imx_e              imx_d;
    dec_t              cls_d;
    dec_t              dec_d, dec_q;

    pdec_swap #(.W(INSN_W)) u_swap (
        .be   (be_mode),
        .raw  (insn_i),
        .word (word_w)
    );

    assign po_w = word_w[31:26];
    assign xo_w = word_w[10:1];
    assign fa_w = word_w[25:21];
    assign fb_w = word_w[20:16];
    assign fc_w = word_w[15:11];

    pdec_imm #(.OUT_W(IMM_W)) u_imm (
        .fld  (word_w[25:0]),
        .mode (imx_d),
        .imm  (imm_w)
    );

    // Classification: every field except the immediate value.
    always_comb begin
        cls_d = '0;
        imx_d = IMX_NONE;
        unique case (po_w)
            PO_ADDI, PO_ADDIS: begin
                cls_d.op  = OPC_ADD;
                cls_d.wr  = '{vld: 1'b1, idx: fa_w};
                cls_d.rd1 = '{vld: (fb_w != '0), idx: fb_w};
                imx_d     = (po_w == PO_ADDIS) ? IMX_SHI : IMX_SLO;
            end
            PO_ORI, PO_ORIS, PO_ANDI, PO_ANDIS: begin
                cls_d.op  = (po_w[2]) ? OPC_AND : OPC_OR;
                cls_d.wr  = '{vld: 1'b1, idx: fb_w};
                cls_d.rd3 = '{vld: 1'b1, idx: fa_w};
                cls_d.rc  = po_w[2];
                imx_d     = po_w[0] ? IMX_UHI : IMX_ULO;
            end
            6'd32, 6'd33, 6'd34, 6'd35, 6'd36, 6'd37, 6'd38, 6'd39,
            6'd40, 6'd41, 6'd44, 6'd45: begin
                cls_d.rd1 = '{vld: (fb_w != '0), idx: fb_w};
                cls_d.upd = po_w[0];
                imx_d     = IMX_SLO;
                if (po_w[3]) cls_d.mlen = 4'd2;
                else if (po_w[1]) cls_d.mlen = 4'd1;
                else cls_d.mlen = 4'd4;
                if (po_w[2]) begin
                    cls_d.op  = OPC_STORE;
                    cls_d.rd3 = '{vld: 1'b1, idx: fa_w};
                end else begin
                    cls_d.op  = OPC_LOAD;
                    cls_d.wr  = '{vld: 1'b1, idx: fa_w};
                end
            end
            PO_X: begin
                unique case (xo_w)
                    XO_ADD: begin
                        cls_d.op  = OPC_ADD;
                        cls_d.wr  = '{vld: 1'b1, idx: fa_w};
                        cls_d.rd1 = '{vld: 1'b1, idx: fb_w};
                        cls_d.rd2 = '{vld: 1'b1, idx: fc_w};
                        cls_d.rc  = word_w[0];
                    end
                    XO_AND, XO_OR: begin
                        cls_d.op  = (xo_w == XO_AND) ? OPC_AND : OPC_OR;
                        cls_d.wr  = '{vld: 1'b1, idx: fb_w};
                        cls_d.rd3 = '{vld: 1'b1, idx: fa_w};
                        cls_d.rd2 = '{vld: 1'b1, idx: fc_w};
                        cls_d.rc  = word_w[0];
                    end
                    XO_CMP: begin
                        cls_d.op  = OPC_CMP;
                        cls_d.rd1 = '{vld: 1'b1, idx: fb_w};
                        cls_d.rd2 = '{vld: 1'b1, idx: fc_w};
                        cls_d.bf  = word_w[25:23];
                    end
                    XO_LDX, XO_STX: begin
                        cls_d.rd1  = '{vld: 1'b1, idx: fb_w};
                        cls_d.rd2  = '{vld: 1'b1, idx: fc_w};
                        cls_d.mlen = 4'd4;
                        if (xo_w == XO_STX) begin
                            cls_d.op  = OPC_STORE;
                            cls_d.rd3 = '{vld: 1'b1, idx: fa_w};
                        end else begin
                            cls_d.op  = OPC_LOAD;
                            cls_d.wr  = '{vld: 1'b1, idx: fa_w};
                        end
                    end
                    default: cls_d = '0;
                endcase
            end
            PO_ROTIMI, PO_ROTINM, PO_ROTNM: begin
                cls_d.op  = OPC_ROTATE;
                cls_d.wr  = '{vld: 1'b1, idx: fb_w};
                cls_d.rd3 = '{vld: 1'b1, idx: fa_w};
                cls_d.mb  = word_w[10:6];
                cls_d.me  = word_w[5:1];
                cls_d.rc  = word_w[0];
                if (po_w == PO_ROTNM) cls_d.rd2 = '{vld: 1'b1, idx: fc_w};
                else cls_d.sh = fc_w;
            end
            PO_B: begin
                cls_d.op = OPC_BRANCH;
                cls_d.aa = word_w[1];
                cls_d.lk = word_w[0];
                imx_d    = IMX_LI;
            end
            PO_BC: begin
                cls_d.op = OPC_BRANCH;
                cls_d.bo = fa_w;
                cls_d.bi = fb_w;
                cls_d.aa = word_w[1];
                cls_d.lk = word_w[0];
                imx_d    = IMX_BD;
            end
            PO_XL: begin
                if (xo_w == XO_TOLR || xo_w == XO_TOCTR) begin
                    cls_d.op  = OPC_BRANCH;
                    cls_d.bo  = fa_w;
                    cls_d.bi  = fb_w;
                    cls_d.lk  = word_w[0];
                    cls_d.spr = (xo_w == XO_TOLR) ? SPRS_LR : SPRS_CTR;
                end
            end
            default: begin
                cls_d = '0;
                imx_d = IMX_NONE;
            end
        endcase
    end

    always_comb begin
        dec_d     = cls_d;
        dec_d.imm = imm_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign op_o      = dec_q.op;
    assign wr_vld_o  = dec_q.wr.vld;
    assign wr_idx_o  = dec_q.wr.idx;
    assign rd1_vld_o = dec_q.rd1.vld;
    assign rd1_idx_o = dec_q.rd1.idx;
    assign rd2_vld_o = dec_q.rd2.vld;
    assign rd2_idx_o = dec_q.rd2.idx;
    assign rd3_vld_o = dec_q.rd3.vld;
    assign rd3_idx_o = dec_q.rd3.idx;
    assign imm_o     = dec_q.imm;
    assign rc_o      = dec_q.rc;
    assign lk_o      = dec_q.lk;
    assign aa_o      = dec_q.aa;
    assign upd_o     = dec_q.upd;
    assign mlen_o    = dec_q.mlen;
    assign bo_o      = dec_q.bo;
    assign bi_o      = dec_q.bi;
    assign bf_o      = dec_q.bf;
    assign sh_o      = dec_q.sh;
    assign mb_o      = dec_q.mb;
    assign me_o      = dec_q.me;
    assign spr_o     = dec_q.spr;

    // R12
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_o == OPC_ILLEGAL) |-> (!wr_vld_o && !rd1_vld_o && !rd2_vld_o && !rd3_vld_o
                                   && mlen_o == 4'd0 && spr_o == SPRS_NONE));

    // R5
    store_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_o == OPC_STORE) |-> (!wr_vld_o && rd3_vld_o));

    // R6
    size_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mlen_o) && ((mlen_o != 4'd0) == (op_o == OPC_LOAD || op_o == OPC_STORE)));

    // R6
    update_mem_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> (op_o == OPC_LOAD || op_o == OPC_STORE));

    // R11
    spr_branch_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_o != SPRS_NONE) |-> (op_o == OPC_BRANCH && !aa_o && imm_o == '0));

    // R7
    record_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rc_o |-> (op_o == OPC_ADD || op_o == OPC_AND || op_o == OPC_OR || op_o == OPC_ROTATE));
endmodule

// File: tb/pdec_stage_test.sv
`timescale 1ns/1ps
module pdec_stage_test;
    import pdec_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        be_mode = 1'b1;
    logic [31:0] insn_i = '0;
    logic [3:0]  op_o, mlen_o;
    logic        wr_vld_o, rd1_vld_o, rd2_vld_o, rd3_vld_o;
    logic [4:0]  wr_idx_o, rd1_idx_o, rd2_idx_o, rd3_idx_o;
    logic [63:0] imm_o;
    logic        rc_o, lk_o, aa_o, upd_o;
    logic [4:0]  bo_o, bi_o, sh_o, mb_o, me_o;
    logic [2:0]  bf_o;
    logic [1:0]  spr_o;

    pdec_stage uut (
        .clk(clk), .rst_n(rst_n), .be_mode(be_mode), .insn_i(insn_i),
        .op_o(op_o), .wr_vld_o(wr_vld_o), .wr_idx_o(wr_idx_o),
        .rd1_vld_o(rd1_vld_o), .rd1_idx_o(rd1_idx_o),
        .rd2_vld_o(rd2_vld_o), .rd2_idx_o(rd2_idx_o),
        .rd3_vld_o(rd3_vld_o), .rd3_idx_o(rd3_idx_o),
        .imm_o(imm_o), .rc_o(rc_o), .lk_o(lk_o), .aa_o(aa_o), .upd_o(upd_o),
        .mlen_o(mlen_o), .bo_o(bo_o), .bi_o(bi_o), .bf_o(bf_o),
        .sh_o(sh_o), .mb_o(mb_o), .me_o(me_o), .spr_o(spr_o)
    );

    always #2 clk = ~clk;

    int n_run  = 0;
    int n_fail = 0;

    logic [3:0]  x_op, x_mlen;
    logic        x_wv, x_r1v, x_r2v, x_r3v, x_rc, x_lk, x_aa, x_upd;
    logic [4:0]  x_wi, x_r1i, x_r2i, x_r3i, x_bo, x_bi, x_sh, x_mb, x_me;
    logic [63:0] x_imm;
    logic [2:0]  x_bf;
    logic [1:0]  x_spr;

    task automatic clr();
        x_op = 0; x_mlen = 0; x_wv = 0; x_r1v = 0; x_r2v = 0; x_r3v = 0;
        x_rc = 0; x_lk = 0; x_aa = 0; x_upd = 0; x_wi = 0; x_r1i = 0;
        x_r2i = 0; x_r3i = 0; x_bo = 0; x_bi = 0; x_sh = 0; x_mb = 0;
        x_me = 0; x_imm = 0; x_bf = 0; x_spr = 0;
    endtask

    function automatic logic [31:0] bswap(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [63:0] sx16(input logic [15:0] v);
        return {{48{v[15]}}, v};
    endfunction

    task automatic fld(input string req, input string nm, input logic [63:0] a,
                       input logic [63:0] e, inout bit bad);
        if (a !== e) begin
            $display("FAIL %s %s: actual %0h expected %0h", req, nm, a, e);
            bad = 1'b1;
        end
    endtask

    task automatic compare(input string req);
        bit bad = 1'b0;
        n_run++;
        fld(req, "op", op_o, x_op, bad);
        fld(req, "wr_vld", wr_vld_o, x_wv, bad);   fld(req, "wr_idx", wr_idx_o, x_wi, bad);
        fld(req, "rd1_vld", rd1_vld_o, x_r1v, bad); fld(req, "rd1_idx", rd1_idx_o, x_r1i, bad);
        fld(req, "rd2_vld", rd2_vld_o, x_r2v, bad); fld(req, "rd2_idx", rd2_idx_o, x_r2i, bad);
        fld(req, "rd3_vld", rd3_vld_o, x_r3v, bad); fld(req, "rd3_idx", rd3_idx_o, x_r3i, bad);
        fld(req, "imm", imm_o, x_imm, bad);         fld(req, "rc", rc_o, x_rc, bad);
        fld(req, "lk", lk_o, x_lk, bad);            fld(req, "aa", aa_o, x_aa, bad);
        fld(req, "upd", upd_o, x_upd, bad);         fld(req, "mlen", mlen_o, x_mlen, bad);
        fld(req, "bo", bo_o, x_bo, bad);            fld(req, "bi", bi_o, x_bi, bad);
        fld(req, "bf", bf_o, x_bf, bad);            fld(req, "sh", sh_o, x_sh, bad);
        fld(req, "mb", mb_o, x_mb, bad);            fld(req, "me", me_o, x_me, bad);
        fld(req, "spr", spr_o, x_spr, bad);
        if (bad) n_fail++;
    endtask

    // Drive a big-endian word in the chosen byte order, then check one edge later.
    task automatic issue(input logic [31:0] w, input logic m, input string req);
        @(negedge clk);
        be_mode = m;
        insn_i  = m ? w : bswap(w);
        @(posedge clk);
        #1;
        compare(req);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #800000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [15:0] ivals [7] = '{16'h0000, 16'h0001, 16'h7fff, 16'h8000,
                                   16'hffff, 16'h1234, 16'ha5c3};
        logic [5:0]  mpo   [12] = '{6'd32, 6'd33, 6'd34, 6'd35, 6'd36, 6'd37,
                                    6'd38, 6'd39, 6'd40, 6'd41, 6'd44, 6'd45};
        logic [4:0]  bolist [8] = '{5'b00000, 5'b00010, 5'b00100, 5'b01000,
                                    5'b01010, 5'b01100, 5'b10000, 5'b10100};
        logic [23:0] lis   [6] = '{24'h000000, 24'h000001, 24'h7fffff,
                                   24'h800000, 24'hffffff, 24'h123456};
        logic [13:0] bds   [5] = '{14'h0000, 14'h0001, 14'h1fff, 14'h2000, 14'h3fff};

        // R2: reset state
        repeat (3) @(posedge clk);
        #1;
        clr();
        compare("R2 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R13 R7 R3: register add, sweeping all register numbers in both byte orders
        for (int r = 0; r < 32; r++) begin
            logic [4:0] a = 5'(r), b = 5'(r + 5), c = 5'(r + 11);
            clr();
            x_op = 4'd1; x_wv = 1; x_wi = a; x_r1v = 1; x_r1i = b; x_r2v = 1; x_r2i = c;
            x_rc = r[0];
            issue({6'd31, a, b, c, 10'd266, r[0]}, r[1], "R13 add");
        end

        // R13 R7: register and / or
        for (int r = 0; r < 32; r++) begin
            logic [4:0] a = 5'(r), b = 5'(r + 3), c = 5'(r + 7);
            clr();
            x_op = r[2] ? 4'd3 : 4'd2; x_wv = 1; x_wi = b; x_r3v = 1; x_r3i = a;
            x_r2v = 1; x_r2i = c; x_rc = r[0];
            issue({6'd31, a, b, c, (r[2] ? 10'd444 : 10'd28), r[0]}, r[3], "R13 logic");
        end

        // R4 R5 R7 R13: immediate ALU forms, every extension mode
        for (int k = 0; k < 7; k++) begin
            for (int j = 0; j < 6; j++) begin
                logic [5:0] po;
                logic [4:0] a = 5'(k + 2 * j + 1);
                logic [4:0] b = (j % 2 == 0) ? 5'd0 : 5'(k + 9);
                logic [15:0] v = ivals[k];
                po = (j == 0) ? 6'd14 : (j == 1) ? 6'd15 : (j == 2) ? 6'd24 :
                     (j == 3) ? 6'd25 : (j == 4) ? 6'd28 : 6'd29;
                clr();
                if (j < 2) begin
                    x_op = 4'd1; x_wv = 1; x_wi = a; x_r1v = (b != 0); x_r1i = b;
                    x_imm = (j == 0) ? sx16(v) : {{32{v[15]}}, v, 16'h0000};
                end else begin
                    x_op = (j >= 4) ? 4'd2 : 4'd3; x_wv = 1; x_wi = b; x_r3v = 1; x_r3i = a;
                    x_imm = (j % 2 == 0) ? {48'h0, v} : {32'h0, v, 16'h0000};
                    x_rc = (j >= 4);
                end
                issue({po, a, b, v}, k[0], "R4 imm alu");
            end
        end

        // R5 R6 R4: D-form loads and stores, base 0 and non-zero
        for (int k = 0; k < 12; k++) begin
            for (int q = 0; q < 3; q++) begin
                logic [5:0] po = mpo[k];
                logic [4:0] a = 5'(k * 3 + q);
                logic [4:0] b = (q == 0) ? 5'd0 : 5'(k + q * 10);
                logic [15:0] v = ivals[(k + q) % 7];
                logic st = (po >= 6'd36 && po <= 6'd39) || po >= 6'd44;
                clr();
                x_op = st ? 4'd5 : 4'd4;
                x_r1v = (b != 0); x_r1i = b;
                if (st) begin x_r3v = 1; x_r3i = a; end
                else begin x_wv = 1; x_wi = a; end
                x_upd = po[0];
                x_mlen = (po == 32 || po == 33 || po == 36 || po == 37) ? 4'd4 :
                         (po >= 34 && po <= 39) ? 4'd1 : 4'd2;
                x_imm = sx16(v);
                issue({po, a, b, v}, q[0], "R5 R6 dform mem");
            end
        end

        // R5 R6: indexed word load and store
        for (int r = 0; r < 8; r++) begin
            logic [4:0] a = 5'(r * 4), b = 5'(r * 3), c = 5'(31 - r);
            clr();
            x_r1v = 1; x_r1i = b; x_r2v = 1; x_r2i = c; x_mlen = 4'd4;
            if (r[0]) begin x_op = 4'd5; x_r3v = 1; x_r3i = a; end
            else begin x_op = 4'd4; x_wv = 1; x_wi = a; end
            issue({6'd31, a, b, c, (r[0] ? 10'd151 : 10'd23), 1'b0}, r[1], "R5 indexed mem");
        end

        // R8: compare, every target field
        for (int f = 0; f < 8; f++) begin
            logic [4:0] b = 5'(f * 4 + 1), c = 5'(f * 2);
            clr();
            x_op = 4'd6; x_r1v = 1; x_r1i = b; x_r2v = 1; x_r2i = c; x_bf = 3'(f);
            issue({6'd31, 3'(f), 2'b00, b, c, 10'd0, 1'b0}, f[0], "R8 cmp");
        end

        // R9 R7: rotate forms
        for (int r = 0; r < 24; r++) begin
            logic [5:0] po = (r % 3 == 0) ? 6'd20 : (r % 3 == 1) ? 6'd21 : 6'd23;
            logic [4:0] a = 5'(r), b = 5'(r + 13), s = 5'(r * 7), mb = 5'(r * 5), me = 5'(31 - r);
            clr();
            x_op = 4'd7; x_wv = 1; x_wi = b; x_r3v = 1; x_r3i = a;
            x_mb = mb; x_me = me; x_rc = r[1];
            if (po == 6'd23) begin x_r2v = 1; x_r2i = s; end
            else x_sh = s;
            issue({po, a, b, s, mb, me, r[1]}, r[2], "R9 rotate");
        end

        // R10: I-form branch
        for (int k = 0; k < 6; k++) begin
            for (int f = 0; f < 4; f++) begin
                clr();
                x_op = 4'd8; x_aa = f[1]; x_lk = f[0];
                x_imm = {{38{lis[k][23]}}, lis[k], 2'b00};
                issue({6'd18, lis[k], f[1], f[0]}, k[0], "R10 iform");
            end
        end

        // R10: B-form conditional branch
        for (int k = 0; k < 5; k++) begin
            for (int g = 0; g < 8; g++) begin
                logic [4:0] bi = 5'(g * 4 + k);
                clr();
                x_op = 4'd8; x_bo = bolist[g]; x_bi = bi; x_aa = g[1]; x_lk = g[0];
                x_imm = {{48{bds[k][13]}}, bds[k], 2'b00};
                issue({6'd16, bolist[g], bi, bds[k], g[1], g[0]}, g[2], "R10 bform");
            end
        end

        // R11: branches through link or count register
        for (int g = 0; g < 16; g++) begin
            logic [4:0] bo = (g % 3 == 0) ? 5'b00100 : (g % 3 == 1) ? 5'b01100 : 5'b10100;
            logic [4:0] bi = 5'(g * 2 + 1);
            logic       toctr = g[1];
            clr();
            x_op = 4'd8; x_bo = bo; x_bi = bi; x_lk = g[0]; x_spr = toctr ? 2'd2 : 2'd1;
            issue({6'd19, bo, bi, 3'b000, 2'(g), (toctr ? 10'd528 : 10'd16), g[0]}, g[2],
                  "R11 xl branch");
        end

        // R12: refused encodings
        clr();
        issue(32'h0000_0000, 1'b1, "R12 opcode0");
        issue({6'd31, 5'd1, 5'd2, 5'd3, 10'd778, 1'b0}, 1'b0, "R12 add oe");
        issue({6'd31, 5'd1, 5'd2, 5'd3, 10'd999, 1'b1}, 1'b1, "R12 x unknown");
        issue({6'd19, 5'd4, 5'd2, 5'd0, 10'd17, 1'b1}, 1'b0, "R12 xl unknown");
        issue({6'd42, 5'd4, 5'd2, 16'h0010}, 1'b1, "R12 opcode42");
        issue({6'd22, 5'd4, 5'd2, 16'h0010}, 1'b0, "R12 opcode22");

        // R1: a big-endian add word given with the reversed-order flag decodes as opcode 5
        @(negedge clk);
        be_mode = 1'b0;
        insn_i  = {6'd31, 5'd1, 5'd2, 5'd3, 10'd266, 1'b0};
        @(posedge clk);
        #1;
        clr();
        compare("R1 reversed raw");

        // R1: the same word with the pass-through flag decodes as add
        clr();
        x_op = 4'd1; x_wv = 1; x_wi = 5'd1; x_r1v = 1; x_r1i = 5'd2; x_r2v = 1; x_r2i = 5'd3;
        issue({6'd31, 5'd1, 5'd2, 5'd3, 10'd266, 1'b0}, 1'b1, "R1 passthrough");

        // R2: a new word is not visible before the next rising edge
        @(negedge clk);
        be_mode = 1'b1;
        insn_i  = {6'd18, 24'h000010, 2'b01};
        #1;
        compare("R2 hold before edge");
        @(posedge clk);
        #1;
        clr();
        x_op = 4'd8; x_lk = 1; x_imm = 64'h40;
        compare("R2 after edge");

        // R2: reset mid-stream clears the record
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        clr();
        compare("R2 async reset");

        summary();
    end
endmodule